// File: doc/BRIEF.md
# Sectored Cache Write-Back Sequencer

This block runs the eviction that has to happen before a read miss in a sectored second-level cache can be filled. A sector holds a fixed number of lines, and each line carries a valid flag and a modified flag. When a miss is handed over, the block takes a snapshot of those flags. It then walks the lines that are both valid and modified, from the lowest line index upward, and reads every quadword of each such line out of the cache data array. Lines that are clean or invalid take no cycles at all.

For each line, the quadword order is interleaved. It starts at the quadword the processor asked for, and each following index is that start XORed with a step count of 0, 1, 2, 3. While a quadword is being read, the command output tells the posted write buffer to take it. In the first cycle after acceptance, the block sends a one-cycle request to the DRAM side, so the memory read overlaps the posting. Once every evicted quadword has been posted, the command changes to the memory-read code for one cycle and a done pulse goes out with it. The block then returns to idle.

Top module: `sector_wb_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `ready` is 1, `cache_rd` is 0, `cmd` is 5'h00, `done` is 0, `dram_req` is 0, and `line_idx` and `qw_idx` are 0.
- R2: A line gets write-back cycles only if its valid and modified bits are both 1 when the miss is accepted. Every such line gets exactly four consecutive cycles with `cache_rd` = 1.
- R3: Selected lines are visited in ascending `line_idx` order. The first quadword of the next selected line follows the last quadword of the previous one with no gap cycle.
- R4: For the k-th cycle of a line (k = 0..3), `qw_idx` equals `miss_qw` XOR k, where `miss_qw` is the start quadword captured at acceptance.
- R5: Every cycle with `cache_rd` = 1 drives `cmd` = 5'h0B, the post-write code.
- R6: In the cycle right after the last posting cycle, `cmd` = 5'h04 (memory read) and `done` = 1 for exactly one cycle. The block is idle in the cycle after that.
- R7: `dram_req` is a one-cycle pulse in the first cycle after a miss is accepted. That cycle is either the first posting cycle or the read cycle.
- R8: If no line is both valid and modified, the cycle right after acceptance already shows `cmd` = 5'h04 with `done` = 1, and there are no posting cycles.
- R9: `miss_req` is accepted only while `ready` = 1. A request raised while busy is ignored and changes nothing in the ongoing sequence.
- R10: Changes to `line_valid`, `line_dirty` or `miss_qw` after acceptance do not affect the sequence that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_req | input | 1 | Read miss needing eviction (taken when ready) |
| miss_qw | input | 2 | Quadword the processor started its access at |
| line_valid | input | 4 | Valid flag of each line in the addressed sector |
| line_dirty | input | 4 | Modified flag of each line in the addressed sector |
| ready | output | 1 | Idle, a new miss can be accepted |
| cache_rd | output | 1 | A quadword is being read from the cache array |
| line_idx | output | 2 | Line index for the cache array (0 when not reading) |
| qw_idx | output | 2 | Quadword index for the cache array (0 when not reading) |
| cmd | output | 5 | Command code: 00 idle, 0B post write, 04 memory read |
| dram_req | output | 1 | One-cycle start request for the DRAM read |
| done | output | 1 | One-cycle pulse with the memory-read command |

## Verification
The bench builds the block with its default shape: four lines per sector, four quadwords per line and a five-bit command. This keeps the whole space small enough to cover completely. Every one of the 16 line-selection masks is combined with each of the four start quadwords. This exercises the empty sector, the full sector, single lines at either end and sparse masks with gaps. The flags and `miss_req` are also scrambled while the block is busy, which tests that acceptance ignores them during that time.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [1:0] {
        SWS_IDLE = 2'd0,
        SWS_POST = 2'd1,
        SWS_READ = 2'd2
    } sws_state_e;

endpackage

// File: rtl/sws_lowest_set.sv
module sws_lowest_set #(
    parameter int WIDTH = 4,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IW-1:0]    idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/sws_burst_order.sv
module sws_burst_order #(
    parameter int QW_W = 2
) (
    input  logic [QW_W-1:0] start,
    input  logic [QW_W-1:0] step,
    output logic [QW_W-1:0] qw
);
    // interleaved order: each step flips the low address bits of the start
    always_comb qw = start ^ step;
endmodule

// File: rtl/sector_wb_seq.sv
module sector_wb_seq #(
    parameter int          LINES    = 4,
    parameter int          QWORDS   = 4,
    parameter int          CMD_W    = 5,
    parameter logic [4:0]  CMD_IDLE = 5'h00,
    parameter logic [4:0]  CMD_POST = 5'h0B,
    parameter logic [4:0]  CMD_READ = 5'h04,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int QW_W   = (QWORDS > 1) ? $clog2(QWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    input  logic [QW_W-1:0]   miss_qw,
    input  logic [LINES-1:0]  line_valid,
    input  logic [LINES-1:0]  line_dirty,
    output logic              ready,
    output logic              cache_rd,
    output logic [LINE_W-1:0] line_idx,
    output logic [QW_W-1:0]   qw_idx,
    output logic [CMD_W-1:0]  cmd,
    output logic              dram_req,
    output logic              done
);
    import sws_pkg::*;

    localparam logic [QW_W-1:0] LAST_STEP = QW_W'(QWORDS - 1);

    typedef struct packed {
        sws_state_e         state;
        logic [LINES-1:0]   pending;
        logic [LINE_W-1:0]  line;
        logic [QW_W-1:0]    start;
        logic [QW_W-1:0]    step;
        logic               dram;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic [LINES-1:0]  scan_vec;
    logic [LINE_W-1:0] scan_idx;
    logic              scan_any;
    logic [QW_W-1:0]   burst_qw;

    // idle: scan the live flags; busy: scan what is still owed
    always_comb begin
        if (cur_q.state == SWS_IDLE) scan_vec = line_valid & line_dirty;
        else                         scan_vec = cur_q.pending;
    end

    sws_lowest_set #(.WIDTH(LINES)) u_pick (
        .vec (scan_vec),
        .idx (scan_idx),
        .any (scan_any)
    );

    sws_burst_order #(.QW_W(QW_W)) u_order (
        .start (cur_q.start),
        .step  (cur_q.step),
        .qw    (burst_qw)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.dram = 1'b0;
        unique case (cur_q.state)
            SWS_IDLE: begin
                if (miss_req) begin
                    nxt_d.dram  = 1'b1;
                    nxt_d.start = miss_qw;
                    nxt_d.step  = '0;
                    if (scan_any) begin
                        nxt_d.state   = SWS_POST;
                        nxt_d.line    = scan_idx;
                        nxt_d.pending = scan_vec & ~(LINES'(1) << scan_idx);
                    end else begin
                        nxt_d.state   = SWS_READ;
                        nxt_d.pending = '0;
                    end
                end
            end
            SWS_POST: begin
                nxt_d.step = cur_q.step + 1'b1;
                if (cur_q.step == LAST_STEP) begin
                    nxt_d.step = '0;
                    if (scan_any) begin
                        nxt_d.line    = scan_idx;
                        nxt_d.pending = cur_q.pending & ~(LINES'(1) << scan_idx);
                    end else begin
                        nxt_d.state = SWS_READ;
                    end
                end
            end
            SWS_READ: begin
                nxt_d.state = SWS_IDLE;
            end
            default: begin
                nxt_d.state = SWS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: SWS_IDLE, pending: '0, line: '0,
                       start: '0, step: '0, dram: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        ready    = (cur_q.state == SWS_IDLE);
        cache_rd = (cur_q.state == SWS_POST);
        done     = (cur_q.state == SWS_READ);
        dram_req = cur_q.dram;
        line_idx = cache_rd ? cur_q.line : '0;
        qw_idx   = cache_rd ? burst_qw   : '0;
        unique case (cur_q.state)
            SWS_POST: cmd = CMD_W'(CMD_POST);
            SWS_READ: cmd = CMD_W'(CMD_READ);
            default:  cmd = CMD_W'(CMD_IDLE);
        endcase
    end
endmodule

// File: rtl/sector_wb_seq_chk.sv
module sector_wb_seq_chk #(
    parameter int         LINE_W   = 2,
    parameter int         QW_W     = 2,
    parameter int         CMD_W    = 5,
    parameter logic [4:0] CMD_IDLE = 5'h00,
    parameter logic [4:0] CMD_POST = 5'h0B,
    parameter logic [4:0] CMD_READ = 5'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_req,
    input logic              ready,
    input logic              cache_rd,
    input logic [LINE_W-1:0] line_idx,
    input logic [QW_W-1:0]   qw_idx,
    input logic [CMD_W-1:0]  cmd,
    input logic              dram_req,
    input logic              done
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!cache_rd && !done && cmd == CMD_W'(CMD_IDLE)));

    p_line_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_rd && $past(cache_rd) && line_idx != $past(line_idx))
            |-> (line_idx > $past(line_idx)));

    p_qw_interleave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_rd && $past(cache_rd) && line_idx == $past(line_idx))
            |-> ((qw_idx ^ $past(qw_idx)) == QW_W'(1) || (qw_idx ^ $past(qw_idx)) == QW_W'(3)));

    p_post_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cache_rd |-> (cmd == CMD_W'(CMD_POST)));

    p_done_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == CMD_W'(CMD_READ) && !cache_rd));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    p_dram_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dram_req |=> !dram_req);

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && miss_req) |=> dram_req);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done) |=> !dram_req);
endmodule

bind sector_wb_seq sector_wb_seq_chk #(
    .LINE_W(LINE_W), .QW_W(QW_W), .CMD_W(CMD_W),
    .CMD_IDLE(CMD_IDLE), .CMD_POST(CMD_POST), .CMD_READ(CMD_READ)
) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .ready(ready),
    .cache_rd(cache_rd), .line_idx(line_idx), .qw_idx(qw_idx),
    .cmd(cmd), .dram_req(dram_req), .done(done)
);

// File: tb/sector_wb_seq_bench.sv
module sector_wb_seq_bench;
    localparam logic [4:0] C_IDLE = 5'h00;
    localparam logic [4:0] C_POST = 5'h0B;
    localparam logic [4:0] C_READ = 5'h04;

    typedef struct packed {
        logic       rdy;
        logic       rd;
        logic [1:0] line;
        logic [1:0] qw;
        logic [4:0] cmd;
        logic       dn;
        logic       dr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss_req = 1'b0;
    logic [1:0] miss_qw = '0;
    logic [3:0] line_valid = '0;
    logic [3:0] line_dirty = '0;
    logic       ready, cache_rd, dram_req, done;
    logic [1:0] line_idx, qw_idx;
    logic [4:0] cmd;

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string phase = "R1 reset";
    exp_t  q[$];

    always #10 clk = ~clk;

    sector_wb_seq u_sector_wb_seq (
        .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_qw(miss_qw),
        .line_valid(line_valid), .line_dirty(line_dirty), .ready(ready),
        .cache_rd(cache_rd), .line_idx(line_idx), .qw_idx(qw_idx),
        .cmd(cmd), .dram_req(dram_req), .done(done)
    );

    function automatic exp_t idle_e();
        exp_t e = '{rdy: 1'b1, rd: 1'b0, line: 2'd0, qw: 2'd0, cmd: C_IDLE, dn: 1'b0, dr: 1'b0};
        return e;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s]: actual=%0h expected=%0h", tag, phase, act, exp);
        end
    endtask

    // one cycle: compare against the model, then drive the next inputs
    task automatic step(input logic req, input logic [3:0] v, input logic [3:0] d,
                        input logic [1:0] s);
        exp_t e;
        bit   first;
        @(negedge clk);
        e = (q.size() != 0) ? q.pop_front() : idle_e();
        chk("R1 R9 ready", int'(ready), int'(e.rdy));
        chk("R2 cache_rd", int'(cache_rd), int'(e.rd));
        chk("R3 line_idx", int'(line_idx), int'(e.line));
        chk("R4 qw_idx", int'(qw_idx), int'(e.qw));
        chk("R5 R6 cmd", int'(cmd), int'(e.cmd));
        chk("R6 R8 done", int'(done), int'(e.dn));
        chk("R7 dram_req", int'(dram_req), int'(e.dr));
        miss_req   = req;
        line_valid = v;
        line_dirty = d;
        miss_qw    = s;
        if (req && e.rdy && rst_n) begin
            first = 1;
            for (int l = 0; l < 4; l++) begin
                if (v[l] && d[l]) begin
                    for (int k = 0; k < 4; k++) begin
                        q.push_back('{rdy: 1'b0, rd: 1'b1, line: 2'(l), qw: s ^ 2'(k),
                                      cmd: C_POST, dn: 1'b0, dr: first});
                        first = 0;
                    end
                end
            end
            q.push_back('{rdy: 1'b0, rd: 1'b0, line: 2'd0, qw: 2'd0,
                          cmd: C_READ, dn: 1'b1, dr: first});
        end
    endtask

    // R10 and R9: while busy, flags and requests are scrambled
    task automatic run_miss(input logic [3:0] v, input logic [3:0] d, input logic [1:0] s);
        step(1'b1, v, d, s);
        while (q.size() != 0)
            step(1'($urandom), 4'($urandom), 4'($urandom), 2'($urandom));
        step(1'b0, 4'($urandom), 4'($urandom), 2'($urandom));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        phase = "R1 reset";
        repeat (3) step(1'b0, 4'hF, 4'hF, 2'd0);
        rst_n = 1'b1;
        step(1'b0, '0, '0, '0);

        phase = "R8 empty sector";
        run_miss(4'h0, 4'h0, 2'd1);
        phase = "R2 valid but clean";
        run_miss(4'hF, 4'h0, 2'd2);
        phase = "R2 dirty but invalid";
        run_miss(4'h0, 4'hF, 2'd3);
        phase = "R3 full sector";
        run_miss(4'hF, 4'hF, 2'd0);
        phase = "R3 sparse 1010";
        run_miss(4'hA, 4'hF, 2'd3);
        phase = "R4 top line only";
        run_miss(4'h8, 4'h8, 2'd1);

        phase = "R2 R3 R4 all masks and starts";
        for (int m = 0; m < 16; m++)
            for (int s = 0; s < 4; s++)
                run_miss(4'(m), 4'hF, 2'(s));

        phase = "R9 R10 random";
        for (int n = 0; n < 300; n++)
            step(1'($urandom), 4'($urandom), 4'($urandom), 2'($urandom));
        while (q.size() != 0) step(1'b0, '0, '0, '0);
        step(1'b0, '0, '0, '0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule